// File: doc/BRIEF.md
# CAN Error Confinement Unit

This block keeps the transmit and receive error counters of a CAN node and derives the node's fault-confinement state from them. The surrounding protocol engine reports events to it as single-cycle strobes. A transmit error, a minor receive error or a major receive error each raises a counter. A successful transmission or reception lowers one. The unit turns the counter values into one of three states: error active, error passive or bus off. It also raises a warning flag when either counter reaches a programmable limit, and it emits one-cycle interrupt pulses whenever the state or the warning flag changes.

While the node is in bus off, every error and success strobe is ignored. The unit then waits for the bus-idle detector, which strobes once for each run of 11 consecutive recessive bits. After a fixed number of such runs, both counters clear and the node returns to error active. Detecting the errors and generating error frames are left to the protocol engine.

Top module: `can_fault_confine`

## Requirements
- R1: After reset both counters read 0, the state reads error active (code 0), the warning flag and both interrupt outputs read 0, and the warning limit is 96.
- R2: Outside bus off, `txErr` adds 8 to the transmit counter, `rxErr` adds 1 to the receive counter and `rxErrMajor` adds 8 to it. When both receive strobes are high together, `rxErrMajor` wins. The new count is visible after the clock edge that samples the strobe.
- R3: Outside bus off, `txOk` subtracts 1 from the transmit counter and `rxOk` subtracts 1 from the receive counter. Neither counter goes below 0. An error strobe for the same counter in the same cycle takes precedence, and the success strobe is then ignored.
- R4: The state is error passive (code 1) when either counter is above 127, and error active (code 0) when both counters are at or below 127. The state output follows the counters one clock edge after they change.
- R5: When a receive error is sampled while either counter is above 127, the receive counter is capped at 135. At no time does the receive counter exceed 135.
- R6: The state is bus off (code 2) when the transmit counter is above 255. While the counters are in that condition, the error and success strobes have no effect on either counter.
- R7: In bus off, each `idle11` strobe counts one recovery run. The clock edge that samples the 128th run clears both counters, and error active follows one edge later. Outside bus off, `idle11` has no effect.
- R8: The warning flag is 1 when either counter is at or above the warning limit, one clock edge after the counters change. A cycle with `limitWr` high loads `limitIn` as the new limit.
- R9: `irqState` is high for exactly the cycle in which the state output takes a new value. `irqWarn` is high for exactly the cycle in which the warning flag takes a new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txErr | input | 1 | Error strobe while transmitting |
| rxErr | input | 1 | Minor error strobe while receiving |
| rxErrMajor | input | 1 | Major error strobe while receiving |
| txOk | input | 1 | Successful transmission strobe |
| rxOk | input | 1 | Successful reception strobe |
| idle11 | input | 1 | Strobe for each run of 11 recessive bits |
| limitWr | input | 1 | Load strobe for the warning limit |
| limitIn | input | 8 | New warning limit |
| txCnt | output | 9 | Transmit error counter |
| rxCnt | output | 9 | Receive error counter |
| state | output | 2 | 0 error active, 1 error passive, 2 bus off |
| warnFlag | output | 1 | Either counter at or above the limit |
| irqState | output | 1 | One-cycle pulse on a state change |
| irqWarn | output | 1 | One-cycle pulse on a warning-flag change |

## Verification
A strobe driven before a rising edge changes the counters at that edge. The state, warning flag and interrupt outputs respond one edge later, because they are computed from the counter values held before that edge. The bench keeps a model of the counters, the limit and the recovery count. It drives each stimulus on a falling edge, advances the model at the rising edge, and at the next falling edge compares the counters with the new model values. It compares the state, warning flag and interrupts with values derived from the model values that held before the update. Directed runs cover the warning threshold, the 0 floor, the cap at 135, strobes ignored in bus off and the 128-run recovery. A long run with a pseudo-random, phase-weighted mix of strobes follows, and it passes repeatedly through bus off and recovery.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_PASSIVE = 2'd1,
    ST_BUSOFF  = 2'd2
  } cfcState_e;

  // control -> datapath strobes for one cycle
  typedef struct packed {
    logic incTx;
    logic incRxMinor;
    logic incRxMajor;
    logic decTx;
    logic decRx;
    logic capRx;
    logic clrAll;
  } cfcCmd_t;

endpackage

// File: rtl/cfc_dp.sv
module cfc_dp
  import cfc_pkg::*;
#(
  parameter int CNT_W     = 9,
  parameter int LIM_W     = 8,
  parameter int TX_STEP   = 8,
  parameter int RX_MAJOR  = 8,
  parameter int RX_SAT    = 135,
  parameter int WARN_DEF  = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  cfcCmd_t          cmd,
  input  logic             limitWr,
  input  logic [LIM_W-1:0] limitIn,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic [LIM_W-1:0] warnLimit
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] txSum;
  logic [SUM_W-1:0] rxSum;
  logic [SUM_W-1:0] rxStep;
  logic [CNT_W-1:0] txNext;
  logic [CNT_W-1:0] rxNext;

  always_comb begin
    txSum  = {1'b0, txCnt} + SUM_W'(TX_STEP);
    rxStep = cmd.incRxMajor ? SUM_W'(RX_MAJOR) : SUM_W'(1);
    rxSum  = {1'b0, rxCnt} + rxStep;
  end

  always_comb begin
    txNext = txCnt;
    if (cmd.clrAll) begin
      txNext = '0;
    end else if (cmd.incTx) begin
      txNext = txSum[CNT_W-1:0];
    end else if (cmd.decTx && txCnt != '0) begin
      txNext = txCnt - CNT_W'(1);
    end
  end

  always_comb begin
    rxNext = rxCnt;
    if (cmd.clrAll) begin
      rxNext = '0;
    end else if (cmd.incRxMinor || cmd.incRxMajor) begin
      if (cmd.capRx && rxSum > SUM_W'(RX_SAT)) begin
        rxNext = CNT_W'(RX_SAT);
      end else begin
        rxNext = rxSum[CNT_W-1:0];
      end
    end else if (cmd.decRx && rxCnt != '0) begin
      rxNext = rxCnt - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txCnt     <= '0;
      rxCnt     <= '0;
      warnLimit <= LIM_W'(WARN_DEF);
    end else begin
      txCnt <= txNext;
      rxCnt <= rxNext;
      if (limitWr) begin
        warnLimit <= limitIn;
      end
    end
  end

endmodule

// File: rtl/cfc_ctrl.sv
module cfc_ctrl
  import cfc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int LIM_W      = 8,
  parameter int PASSIVE_TH = 127,
  parameter int BUSOFF_TH  = 255,
  parameter int RECOV_N    = 128
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             rxErrMajor,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             idle11,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  input  logic [LIM_W-1:0] warnLimit,
  output cfcCmd_t          cmd,
  output cfcState_e        stateQ,
  output logic             warnQ,
  output logic             irqStateQ,
  output logic             irqWarnQ
);

  localparam int REC_W = $clog2(RECOV_N + 1);

  logic             busOffNow;
  logic             passiveNow;
  logic             warnNow;
  logic             lastRun;
  logic [REC_W-1:0] recCnt;
  cfcState_e        stateNext;

  always_comb begin
    busOffNow  = txCnt > CNT_W'(BUSOFF_TH);
    passiveNow = (txCnt > CNT_W'(PASSIVE_TH)) || (rxCnt > CNT_W'(PASSIVE_TH));
    warnNow    = (txCnt >= CNT_W'(warnLimit)) || (rxCnt >= CNT_W'(warnLimit));
    lastRun    = recCnt == REC_W'(RECOV_N - 1);
  end

  always_comb begin
    if (busOffNow)       stateNext = ST_BUSOFF;
    else if (passiveNow) stateNext = ST_PASSIVE;
    else                 stateNext = ST_ACTIVE;
  end

  always_comb begin
    cmd.incTx      = !busOffNow && txErr;
    cmd.incRxMajor = !busOffNow && rxErrMajor;
    cmd.incRxMinor = !busOffNow && rxErr && !rxErrMajor;
    cmd.decTx      = !busOffNow && txOk && !txErr;
    cmd.decRx      = !busOffNow && rxOk && !rxErr && !rxErrMajor;
    cmd.capRx      = passiveNow;
    cmd.clrAll     = busOffNow && idle11 && lastRun;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      recCnt <= '0;
    end else if (!busOffNow) begin
      recCnt <= '0;
    end else if (idle11) begin
      recCnt <= lastRun ? '0 : recCnt + REC_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= ST_ACTIVE;
      warnQ     <= 1'b0;
      irqStateQ <= 1'b0;
      irqWarnQ  <= 1'b0;
    end else begin
      stateQ    <= stateNext;
      warnQ     <= warnNow;
      irqStateQ <= stateNext != stateQ;
      irqWarnQ  <= warnNow != warnQ;
    end
  end

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine
  import cfc_pkg::*;
#(
  parameter int CNT_W      = 9,
  parameter int LIM_W      = 8,
  parameter int TX_STEP    = 8,
  parameter int RX_MAJOR   = 8,
  parameter int RX_SAT     = 135,
  parameter int PASSIVE_TH = 127,
  parameter int BUSOFF_TH  = 255,
  parameter int RECOV_N    = 128,
  parameter int WARN_DEF   = 96
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txErr,
  input  logic             rxErr,
  input  logic             rxErrMajor,
  input  logic             txOk,
  input  logic             rxOk,
  input  logic             idle11,
  input  logic             limitWr,
  input  logic [LIM_W-1:0] limitIn,
  output logic [CNT_W-1:0] txCnt,
  output logic [CNT_W-1:0] rxCnt,
  output logic [1:0]       state,
  output logic             warnFlag,
  output logic             irqState,
  output logic             irqWarn
);

  cfcCmd_t          cmd;
  cfcState_e        stateQ;
  logic [LIM_W-1:0] warnLimit;

  cfc_ctrl #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .PASSIVE_TH(PASSIVE_TH),
    .BUSOFF_TH(BUSOFF_TH), .RECOV_N(RECOV_N)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr),
    .rxErrMajor(rxErrMajor), .txOk(txOk), .rxOk(rxOk), .idle11(idle11),
    .txCnt(txCnt), .rxCnt(rxCnt), .warnLimit(warnLimit), .cmd(cmd),
    .stateQ(stateQ), .warnQ(warnFlag), .irqStateQ(irqState), .irqWarnQ(irqWarn)
  );

  cfc_dp #(
    .CNT_W(CNT_W), .LIM_W(LIM_W), .TX_STEP(TX_STEP), .RX_MAJOR(RX_MAJOR),
    .RX_SAT(RX_SAT), .WARN_DEF(WARN_DEF)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .limitWr(limitWr), .limitIn(limitIn),
    .txCnt(txCnt), .rxCnt(rxCnt), .warnLimit(warnLimit)
  );

  assign state = stateQ;

endmodule

// File: rtl/cfc_checker.sv
module cfc_checker #(
  parameter int CNT_W      = 9,
  parameter int TX_STEP    = 8,
  parameter int RX_SAT     = 135,
  parameter int PASSIVE_TH = 127,
  parameter int BUSOFF_TH  = 255
) (
  input logic             clk,
  input logic             rstN,
  input logic             txErr,
  input logic             txOk,
  input logic             idle11,
  input logic [CNT_W-1:0] txCnt,
  input logic [CNT_W-1:0] rxCnt,
  input logic [1:0]       state,
  input logic             irqState
);

  logic inBusOff;
  assign inBusOff = txCnt > CNT_W'(BUSOFF_TH);

  a_r2_tx_step: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !inBusOff) |=> (txCnt == $past(txCnt) + CNT_W'(TX_STEP)));

  a_r3_tx_floor: assert property (@(posedge clk) disable iff (!rstN)
    (txOk && !txErr && txCnt == '0) |=> (txCnt == '0));

  a_r4_passive_state: assert property (@(posedge clk) disable iff (!rstN)
    (!inBusOff && (txCnt > CNT_W'(PASSIVE_TH) || rxCnt > CNT_W'(PASSIVE_TH)))
      |=> (state == 2'd1 || state == 2'd2));

  a_r5_rx_cap: assert property (@(posedge clk) disable iff (!rstN)
    rxCnt <= CNT_W'(RX_SAT));

  a_r6_busoff_hold: assert property (@(posedge clk) disable iff (!rstN)
    (inBusOff && !idle11) |=> ($stable(txCnt) && $stable(rxCnt)));

  a_r6_busoff_state: assert property (@(posedge clk) disable iff (!rstN)
    inBusOff |=> (state == 2'd2));

  a_r9_irq_on_change: assert property (@(posedge clk) disable iff (!rstN)
    irqState |-> (state != $past(state)));

endmodule

bind can_fault_confine cfc_checker #(
  .CNT_W(CNT_W), .TX_STEP(TX_STEP), .RX_SAT(RX_SAT),
  .PASSIVE_TH(PASSIVE_TH), .BUSOFF_TH(BUSOFF_TH)
) u_chk (
  .clk(clk), .rstN(rstN), .txErr(txErr), .txOk(txOk), .idle11(idle11),
  .txCnt(txCnt), .rxCnt(rxCnt), .state(state), .irqState(irqState)
);

// File: tb/can_fault_confine_bench.sv
module can_fault_confine_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txErr = 1'b0, rxErr = 1'b0, rxErrMajor = 1'b0;
  logic       txOk = 1'b0, rxOk = 1'b0, idle11 = 1'b0, limitWr = 1'b0;
  logic [7:0] limitIn = 8'd0;
  logic [8:0] txCnt, rxCnt;
  logic [1:0] state;
  logic       warnFlag, irqState, irqWarn;

  int total = 0;
  int bad = 0;
  int mTx = 0, mRx = 0, mRc = 0, mLim = 96;
  int mState = 0, mWarn = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  can_fault_confine u_can_fault_confine (
    .clk(clk), .rstN(rstN), .txErr(txErr), .rxErr(rxErr),
    .rxErrMajor(rxErrMajor), .txOk(txOk), .rxOk(rxOk), .idle11(idle11),
    .limitWr(limitWr), .limitIn(limitIn), .txCnt(txCnt), .rxCnt(rxCnt),
    .state(state), .warnFlag(warnFlag), .irqState(irqState), .irqWarn(irqWarn)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int stateOf(input int t, input int r);
    if (t > 255) return 2;
    if (t > 127 || r > 127) return 1;
    return 0;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic step(input bit te, input bit re, input bit rm, input bit to,
                      input bit ro, input bit id, input bit lw, input int lv,
                      input string tag);
    int oldState, newState, newWarn, inc;
    bit pas;
    txErr = te; rxErr = re; rxErrMajor = rm; txOk = to; rxOk = ro;
    idle11 = id; limitWr = lw; limitIn = 8'(lv);
    @(posedge clk);
    oldState = mState;
    newState = stateOf(mTx, mRx);
    newWarn  = (mTx >= mLim || mRx >= mLim) ? 1 : 0;
    pas = (mTx > 127 || mRx > 127);
    if (mTx > 255) begin
      if (id) begin
        mRc++;
        if (mRc == 128) begin mTx = 0; mRx = 0; mRc = 0; end
      end
    end else begin
      mRc = 0;
      if (te) mTx += 8;
      else if (to && mTx > 0) mTx--;
      inc = rm ? 8 : (re ? 1 : 0);
      if (inc != 0) begin
        mRx += inc;
        if (pas && mRx > 135) mRx = 135;
      end else if (ro && mRx > 0) mRx--;
    end
    if (lw) mLim = lv;
    @(negedge clk);
    check(tag, "txCnt", int'(txCnt), mTx);
    check(tag, "rxCnt", int'(rxCnt), mRx);
    check("R4", "state", int'(state), newState);
    check("R8", "warnFlag", int'(warnFlag), newWarn);
    check("R9", "irqState", int'(irqState), (newState != oldState) ? 1 : 0);
    check("R9", "irqWarn", int'(irqWarn), (newWarn != mWarn) ? 1 : 0);
    mState = newState;
    mWarn = newWarn;
    txErr = 0; rxErr = 0; rxErrMajor = 0; txOk = 0; rxOk = 0;
    idle11 = 0; limitWr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "txCnt", int'(txCnt), 0);
    check("R1", "rxCnt", int'(rxCnt), 0);
    check("R1", "state", int'(state), 0);
    check("R1", "warnFlag", int'(warnFlag), 0);
    check("R1", "irqState", int'(irqState), 0);
    check("R1", "irqWarn", int'(irqWarn), 0);

    // default limit 96 by minor receive errors (R1, R8)
    for (int i = 0; i < 95; i++) step(0,1,0,0,0,0,0,0,"R2");
    step(0,0,0,0,0,0,0,0,"R8");
    check("R1", "warn below default limit", int'(warnFlag), 0);
    step(0,1,0,0,0,0,0,0,"R2");
    step(0,0,0,0,0,0,0,0,"R8");
    check("R8", "warn at 96", int'(warnFlag), 1);
    // decrement to floor, beyond zero (R3)
    for (int i = 0; i < 100; i++) step(0,0,0,0,1,0,0,0,"R3");
    check("R3", "rx floor", int'(rxCnt), 0);
    for (int i = 0; i < 3; i++) step(0,0,0,1,0,0,0,0,"R3");
    check("R3", "tx floor", int'(txCnt), 0);
    // error beats success in same cycle
    step(1,0,0,1,0,0,0,0,"R3");
    step(0,1,0,0,1,0,0,0,"R3");
    step(0,1,1,0,0,0,0,0,"R2");
    check("R2", "major wins", int'(rxCnt), 9);
    for (int i = 0; i < 9; i++) step(0,0,0,0,1,0,0,0,"R3");
    // into passive via transmit errors
    for (int i = 0; i < 16; i++) step(1,0,0,0,0,0,0,0,"R2");
    step(0,0,0,0,0,0,0,0,"R4");
    check("R4", "passive at tx 136", int'(state), 1);
    // receive saturation while passive
    for (int i = 0; i < 20; i++) step(0,0,1,0,0,0,0,0,"R5");
    check("R5", "rx capped", int'(rxCnt), 135);
    for (int i = 0; i < 5; i++) step(0,1,0,0,0,0,0,0,"R5");
    check("R5", "rx capped minor", int'(rxCnt), 135);
    for (int i = 0; i < 9; i++) step(0,0,0,1,0,0,0,0,"R4");
    for (int i = 0; i < 8; i++) step(0,0,0,0,1,0,0,0,"R4");
    step(0,0,0,0,0,0,0,0,"R4");
    check("R4", "back to active", int'(state), 0);
    // bus off
    for (int i = 0; i < 17; i++) step(1,0,0,0,0,0,0,0,"R6");
    step(0,0,0,0,0,0,0,0,"R6");
    check("R6", "bus off", int'(state), 2);
    step(0,0,0,1,1,0,0,0,"R6");
    step(1,1,1,0,0,0,0,0,"R6");
    check("R6", "tx held", int'(txCnt), 263);
    // recovery
    for (int i = 0; i < 127; i++) step(0,0,0,0,0,1,0,0,"R7");
    check("R7", "still bus off at 127 runs", int'(state), 2);
    step(0,0,0,0,0,1,0,0,"R7");
    check("R7", "tx cleared", int'(txCnt), 0);
    step(0,0,0,0,0,1,0,0,"R7");
    check("R7", "active after recovery", int'(state), 0);
    check("R7", "idle outside bus off", int'(txCnt), 0);
    // programmable limit
    step(0,0,0,0,0,0,1,10,"R8");
    for (int i = 0; i < 10; i++) step(0,1,0,0,0,0,0,0,"R8");
    step(0,0,0,0,0,0,0,0,"R8");
    check("R8", "warn at limit 10", int'(warnFlag), 1);
    step(0,0,0,0,0,0,1,200,"R8");
    step(0,0,0,0,0,0,0,0,"R8");
    check("R8", "warn cleared by limit 200", int'(warnFlag), 0);
    // pseudo-random phase-weighted sweep
    for (int i = 0; i < 6000; i++) begin
      bit hot;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      hot = ((i / 400) % 2) == 0;
      step(hot ? lfsr[0] : (lfsr[2:0] == 3'd0),
           lfsr[3], lfsr[5:4] == 2'd0,
           lfsr[6], lfsr[7] | ~hot,
           lfsr[8] | lfsr[9],
           lfsr[15:10] == 6'd0, int'({2'b0, lfsr[14:9]}) + 60,
           "R2");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule